// File: doc/BRIEF.md
# Configurable-Order Sigma-Delta Fractional Modulator

This block makes a fractional-N feedback divider average a non-integer ratio. It fires once per comparison cycle, on a single-cycle `step` strobe taken from the divided reference. Each time it fires, it produces a small signed correction. That correction is added to the integer ratio `int_div`, which comes from the main and swallow counters, together with a fixed offset of three. The result, `div_ratio`, is the ratio the divider uses next. Over time the correction averages to `frac_in / 2^20`.

The modulator is a chain of three first-order accumulators, each 20 bits wide and wrapping at 2^20. Their carries are recombined through difference stages. One configuration bit chooses second-order shaping, which uses two stages, or third-order shaping, which uses all three. A numerator of zero stops every accumulator, and the loop then behaves as a plain integer-N loop.

The numerator and order are captured on a `load` strobe. The same strobe clears the accumulator history, so the sequence always starts from a known state.

Top module: `sdm_frac_mod`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `corr` to 0 and the captured numerator to 0. After reset, `div_ratio` therefore equals `int_div + 3`.
- R2: On a clock edge with `load` high, the block captures `frac_in` and `order_sel` and clears all accumulators and carry delays. `corr` reads 0 from the following cycle. If `load` and `step` are high in the same cycle, `load` wins and `step` is ignored.
- R3: `corr` changes only on a clock edge with `step` high and `load` low. The new value is visible from the cycle after that edge. With no strobe, `corr` holds its value.
- R4: With a captured numerator of 0, every step leaves `corr` at 0.
- R5: With `order_sel` = 0 (second order), `corr` stays within -1..+2. With `order_sel` = 1 (third order), `corr` stays within -3..+4.
- R6: Let S be the sum of the `corr` values over the N steps after a load, and let E = floor(N·F/2^20). In second order, S − E stays in 0..+1. In third order, S − E stays in -1..+2.
- R7: Each stage adds the updated content of the stage before it; the first stage adds F. As a result, with F = 524288, the steps after a load give the sequence 0, 1, 1, 0 repeating in second order and 0, 2, -1, 1 repeating in third order.
- R8: `div_ratio` always equals `int_div + 3 + corr`, with `corr` sign-extended and the sum taken modulo 2^16. It follows `int_div` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (divided reference domain) |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture numerator and order; clear history |
| step | input | 1 | One-cycle strobe per divider-output cycle |
| frac_in | input | 20 | Fractional numerator F, 0..1048575 |
| order_sel | input | 1 | 0 selects second order, 1 selects third order |
| int_div | input | 16 | Integer ratio from main and swallow counters |
| corr | output | 4 | Registered signed correction |
| div_ratio | output | 16 | int_div + 3 + corr |

## Verification
The checker tracks the configuration only through `load`. It therefore assumes that `frac_in` and `order_sel` matter solely at a load edge, and that the numerator-zero bypass depends on the captured value and not on the live input. The stimulus changes these inputs only together with `load`, and sometimes raises `load` and `step` in the same cycle to exercise the priority rule. Long runs with non-power-of-two numerators exercise the range and cumulative-sum bounds. Short runs at F = 2^19 pin down the exact sequence in each order.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
    localparam int CORR_W = 4;
    localparam int NSTAGE = 3;

    typedef logic signed [CORR_W-1:0] corr_t;

    typedef enum logic {
        ORD_SECOND = 1'b0,
        ORD_THIRD  = 1'b1
    } order_e;
endpackage

// File: rtl/sdm_accum.sv
module sdm_accum #(
    parameter int W = 20
) (
    input  logic [W-1:0] acc_q,
    input  logic [W-1:0] addend,
    output logic [W-1:0] sum,
    output logic         carry
);
    logic [W:0] wide;

    always_comb begin
        wide  = {1'b0, acc_q} + {1'b0, addend};
        sum   = wide[W-1:0];
        carry = wide[W];
    end
endmodule

// File: rtl/sdm_noise_shape.sv
module sdm_noise_shape
    import sdm_pkg::*;
(
    input  logic [NSTAGE-1:0] carry,
    input  logic              c2_dly,
    input  logic              c3_dly1,
    input  logic              c3_dly2,
    input  order_e            order,
    output corr_t             y
);
    localparam int PADW = CORR_W - 1;

    corr_t s1, s2, s2d, s3, s3d1, s3d2, diff2, diff3;

    always_comb begin
        s1    = corr_t'({{PADW{1'b0}}, carry[0]});
        s2    = corr_t'({{PADW{1'b0}}, carry[1]});
        s2d   = corr_t'({{PADW{1'b0}}, c2_dly});
        s3    = corr_t'({{PADW{1'b0}}, carry[2]});
        s3d1  = corr_t'({{PADW{1'b0}}, c3_dly1});
        s3d2  = corr_t'({{PADW{1'b0}}, c3_dly2});
        diff2 = s2 - s2d;
        diff3 = s3 - s3d1 - s3d1 + s3d2;
        if (order == ORD_THIRD)
            y = s1 + diff2 + diff3;
        else
            y = s1 + diff2;
    end
endmodule

// File: rtl/sdm_frac_mod.sv
module sdm_frac_mod
    import sdm_pkg::*;
#(
    parameter int FRAC_W     = 20,
    parameter int DIV_W      = 16,
    parameter int DIV_OFFSET = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic                     step,
    input  logic [FRAC_W-1:0]        frac_in,
    input  logic                     order_sel,
    input  logic [DIV_W-1:0]         int_div,
    output logic signed [CORR_W-1:0] corr,
    output logic [DIV_W-1:0]         div_ratio
);
    localparam int EXT_W = DIV_W - CORR_W;

    typedef struct packed {
        logic [FRAC_W-1:0]             frac;
        order_e                        order;
        logic [NSTAGE-1:0][FRAC_W-1:0] acc;
        logic                          c2_dly;
        logic                          c3_dly1;
        logic                          c3_dly2;
        corr_t                         corr;
    } state_t;

    state_t st_d, st_q;

    logic [NSTAGE-1:0][FRAC_W-1:0] addends;
    logic [NSTAGE-1:0][FRAC_W-1:0] sums;
    logic [NSTAGE-1:0]             carries;
    corr_t                         shaped;

    // Cascade of first-order accumulators: each stage adds the updated
    // content of the previous one.
    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign addends[g] = st_q.frac;
        end else begin : g_tail
            assign addends[g] = sums[g-1];
        end
        sdm_accum #(.W(FRAC_W)) u_acc (
            .acc_q (st_q.acc[g]),
            .addend(addends[g]),
            .sum   (sums[g]),
            .carry (carries[g])
        );
    end

    sdm_noise_shape u_shape (
        .carry  (carries),
        .c2_dly (st_q.c2_dly),
        .c3_dly1(st_q.c3_dly1),
        .c3_dly2(st_q.c3_dly2),
        .order  (st_q.order),
        .y      (shaped)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.frac    = frac_in;
            st_d.order   = order_e'(order_sel);
            st_d.acc     = '0;
            st_d.c2_dly  = 1'b0;
            st_d.c3_dly1 = 1'b0;
            st_d.c3_dly2 = 1'b0;
            st_d.corr    = '0;
        end else if (step) begin
            if (st_q.frac == '0) begin
                // pure integer-N: modulator frozen
                st_d.corr = '0;
            end else begin
                st_d.acc     = sums;
                st_d.c2_dly  = carries[1];
                st_d.c3_dly1 = carries[2];
                st_d.c3_dly2 = st_q.c3_dly1;
                st_d.corr    = shaped;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        corr      = st_q.corr;
        div_ratio = int_div + DIV_W'(DIV_OFFSET)
                  + {{EXT_W{st_q.corr[CORR_W-1]}}, st_q.corr};
    end
endmodule

// File: rtl/sdm_frac_mod_chk.sv
module sdm_frac_mod_chk #(
    parameter int FRAC_W = 20
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    load,
    input logic                    step,
    input logic [FRAC_W-1:0]       frac_in,
    input logic                    order_sel,
    input logic signed [3:0]       corr
);
    logic ord_c;
    logic zero_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            ord_c  <= 1'b0;
            zero_c <= 1'b1;
        end else if (load) begin
            ord_c  <= order_sel;
            zero_c <= (frac_in == '0);
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> corr == 4'sd0);

    assert_load_clear_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> corr == 4'sd0);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(corr));

    assert_zero_bypass_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !load && zero_c) |=> corr == 4'sd0);

    assert_range_second_R5: assert property (@(posedge clk) disable iff (rst)
        !ord_c |-> (corr >= -4'sd1 && corr <= 4'sd2));

    assert_range_third_R5: assert property (@(posedge clk) disable iff (rst)
        ord_c |-> (corr >= -4'sd3 && corr <= 4'sd4));
endmodule

bind sdm_frac_mod sdm_frac_mod_chk #(.FRAC_W(FRAC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .frac_in  (frac_in),
    .order_sel(order_sel),
    .corr     (corr)
);

// File: tb/tb_sdm_frac_mod.sv
module tb_sdm_frac_mod;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               load = 1'b0;
    logic               step = 1'b0;
    logic [19:0]        frac_in = '0;
    logic               order_sel = 1'b0;
    logic [15:0]        int_div = 16'd100;
    logic signed [3:0]  corr;
    logic [15:0]        div_ratio;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sdm_frac_mod dut (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .frac_in(frac_in), .order_sel(order_sel), .int_div(int_div),
        .corr(corr), .div_ratio(div_ratio)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [19:0] f, input logic o);
        @(negedge clk);
        load = 1'b1; frac_in = f; order_sel = o;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic do_step();
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(corr == 0, "R1 corr after reset", corr, 0);
        chk(div_ratio == 16'd103, "R1 div_ratio after reset", div_ratio, 103);
    endtask

    task automatic t_seq(input logic o, input int e0, input int e1, input int e2, input int e3);
        int exp_v[4];
        exp_v = '{e0, e1, e2, e3};
        do_load(20'd524288, o);
        chk(corr == 0, "R2 corr after load", corr, 0);
        for (int i = 0; i < 12; i++) begin
            do_step();
            chk(corr == exp_v[i % 4], o ? "R7 third-order sequence" : "R7 second-order sequence",
                corr, exp_v[i % 4]);
        end
    endtask

    task automatic t_hold_and_ratio();
        do_load(20'd524288, 1'b1);
        do_step(); do_step();
        chk(corr == 2, "R7 setup", corr, 2);
        int_div = 16'd1000;
        repeat (6) @(negedge clk);
        chk(corr == 2, "R3 hold without step", corr, 2);
        chk(div_ratio == 16'd1005, "R8 ratio with +2", div_ratio, 1005);
        do_step();
        chk(corr == -1, "R3 step update", corr, -1);
        chk(div_ratio == 16'd1002, "R8 ratio with -1", div_ratio, 1002);
        int_div = 16'd100;
    endtask

    task automatic t_priority();
        do_load(20'd524288, 1'b1);
        do_step(); do_step();
        @(negedge clk);
        load = 1'b1; step = 1'b1; frac_in = 20'd524288; order_sel = 1'b1;
        @(negedge clk);
        load = 1'b0; step = 1'b0;
        chk(corr == 0, "R2 load beats step", corr, 0);
        do_step();
        chk(corr == 0, "R2 history cleared first", corr, 0);
        do_step();
        chk(corr == 2, "R2 history cleared second", corr, 2);
    endtask

    task automatic t_zero();
        do_load(20'd0, 1'b1);
        for (int i = 0; i < 10; i++) begin
            do_step();
            chk(corr == 0, "R4 zero numerator", corr, 0);
        end
        chk(div_ratio == 16'd103, "R4 integer ratio", div_ratio, 103);
    endtask

    task automatic t_average(input logic [19:0] f, input logic o, input int n);
        longint sum = 0;
        longint e;
        longint lo = o ? -1 : 0;
        longint hi = o ? 2 : 1;
        longint rlo = o ? -3 : -1;
        longint rhi = o ? 4 : 2;
        do_load(f, o);
        for (int i = 1; i <= n; i++) begin
            do_step();
            chk(corr >= rlo && corr <= rhi, "R5 range", corr, rhi);
            sum += corr;
            e = (longint'(i) * longint'(f)) >>> 20;
            chk(sum - e >= lo && sum - e <= hi, "R6 cumulative error", sum - e, e);
        end
    endtask

    initial begin
        #(10 * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_seq(1'b0, 0, 1, 1, 0);
        t_seq(1'b1, 0, 2, -1, 1);
        t_hold_and_ratio();
        t_priority();
        t_zero();
        t_average(20'd32263, 1'b1, 7000);
        t_average(20'd572683, 1'b0, 7000);
        t_average(20'd1048575, 1'b1, 5000);
        t_average(20'd1, 1'b0, 3000);
        t_average(20'd262149, 1'b1, 5000);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule